// File: doc/BRIEF.md
# Standard-Definition Sync Slave Decoder

This block sits behind a standard-definition video input that is driven by external timing. It watches an active-low horizontal sync, a field level and an optional active-low blank input, and from them rebuilds the current line number, the odd/even field and a pulse at each new frame. It runs on a clock at twice the pixel rate, which is one multiplexed sample per clock. The pixel stream arrives as Cb, Y, Cr, Y and repeats. The block splits it into chroma pairs and luma pairs and marks each finished group with a valid strobe.

A new frame is recognised only when the field level falls while horizontal sync is held low. A rise of the field level under the same condition starts the second field. A toggle of the field level while sync is high is ignored.

Vertical blanking is always derived from the internal line count. The external blank input can add blanking when it is enabled. PAL (625 lines) and NTSC (525 lines) timings are chosen by one select input. The three timing inputs are also forwarded, one clock later, to three sync outputs.

Top module: `sd_sync_slave`

## Requirements
- R1: While reset is held: lineNum = 1, oddField = 1, frameStart = 0, blankOut = 1, pixValid = 0, syncH = 1, syncBlank = 1 and syncV = 0.
- R2: lineNum increases by one at the clock edge where hsyncN is first sampled low after being sampled high. After the last line (625 for PAL, 525 for NTSC) it returns to 1, and this wrap raises no frameStart. lineNum never changes while hsyncN is high.
- R3: A fall of fieldIn (1 to 0) that is sampled while hsyncN is low starts a frame. At that same edge lineNum becomes 1, oddField becomes 1 and frameStart is high for exactly one clock.
- R4: A rise of fieldIn (0 to 1) that is sampled while hsyncN is low starts the second field. At that edge lineNum becomes 313 (PAL) or 263 (NTSC) and oddField becomes 0, with no frameStart.
- R5: A change of fieldIn while hsyncN is high does not alter lineNum or oddField and raises no frameStart.
- R6: blankOut is 1 on the clock after lineNum lies in the internal blanking ranges, whatever the blank input does. The ranges are lines 1–22 and 313–335 for PAL, and lines 1–20 and 263–283 for NTSC.
- R7: With blankEn = 1, a low on blankN forces blankOut to 1 one edge later. With blankEn = 0, blankN has no effect on blankOut.
- R8: The first sample taken after blanking is a Cb. It is the pixIn value present at the 12th (PAL) or 16th (NTSC) clock edge after the edge at which blankOut fell. The following samples are taken in the order Y0, Cr, Y1, repeating.
- R9: At the edge that takes Y1, pixValid goes high for one clock, with cbOut = Cb, crOut = Cr and yOut = {Y0, Y1} (Y0 in the upper byte). This repeats every 4 clocks. pixValid stays low on the clock after blankOut is 1.
- R10: syncH, syncBlank and syncV carry hsyncN, blankN and fieldIn as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, twice the pixel rate |
| rstN | input | 1 | Asynchronous active-low reset |
| hsyncN | input | 1 | Active-low horizontal sync |
| fieldIn | input | 1 | Field level, 0 = odd field |
| blankN | input | 1 | Optional active-low external blank |
| blankEn | input | 1 | 1 = use blankN |
| isPal | input | 1 | 1 = PAL timing, 0 = NTSC timing |
| pixIn | input | DATA_W | Multiplexed Cb/Y/Cr samples |
| lineNum | output | LINE_W | Current line, 1-based |
| oddField | output | 1 | 1 while in the first field |
| frameStart | output | 1 | One-clock pulse at a new frame |
| blankOut | output | 1 | Composite blank, 1 = blanked |
| yOut | output | 2*DATA_W | Luma pair {Y0, Y1} |
| cbOut | output | DATA_W | Cb sample of the pair |
| crOut | output | DATA_W | Cr sample of the pair |
| pixValid | output | 1 | One-clock strobe for a new Y/Cb/Cr group |
| syncH | output | 1 | Forwarded horizontal sync |
| syncBlank | output | 1 | Forwarded blank |
| syncV | output | 1 | Forwarded field |

## Verification
A line counter that is off by even one line shows up at the ports within two clocks: blankOut either clears one line too early or too late, and the first line of the next field comes out wrong. An error in the sample phase or in the start delay after blanking corrupts the first group emitted, 12 or 16 clocks after blank ends. Every byte of that group is distinct, so a slip of even one position cannot hide. A field edge that is mistaken for a frame start, or a missed one, shows up on frameStart and lineNum at the very next edge.

// File: rtl/sd_sync_pkg.sv
`timescale 1ns/1ps
package sd_sync_pkg;
  // Capture strobes from the control side to the datapath.
  typedef struct packed {
    logic capCb;
    logic capY0;
    logic capCr;
    logic capY1;
  } pixStrobe_t;
endpackage

// File: rtl/sd_sync_ctrl.sv
`timescale 1ns/1ps
module sd_sync_ctrl
  import sd_sync_pkg::*;
#(
  parameter int LINE_W       = 10,
  parameter int PAL_LINES    = 625,
  parameter int NTSC_LINES   = 525,
  parameter int PAL_F2_LINE  = 313,
  parameter int NTSC_F2_LINE = 263,
  parameter int PAL_ACT1     = 23,
  parameter int PAL_ACT2     = 336,
  parameter int NTSC_ACT1    = 21,
  parameter int NTSC_ACT2    = 284,
  parameter int PAL_SKIP     = 12,
  parameter int NTSC_SKIP    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hsyncN,
  input  logic              fieldIn,
  input  logic              blankN,
  input  logic              blankEn,
  input  logic              isPal,
  output logic [LINE_W-1:0] lineNum,
  output logic              oddField,
  output logic              frameStart,
  output logic              blankOut,
  output pixStrobe_t        strobe
);
  localparam int MAX_SKIP = (PAL_SKIP > NTSC_SKIP) ? PAL_SKIP : NTSC_SKIP;
  localparam int SKIP_W   = $clog2(MAX_SKIP + 1);

  logic              hPrev, fPrev;
  logic              hFall, toOdd, toEven;
  logic [LINE_W-1:0] lineTotal, f2Line, act1, act2;
  logic              intBlank, extBlank;
  logic [SKIP_W-1:0] skipCnt, skipLoad;
  logic [1:0]        phase;
  logic              capEn;

  // Per-standard line constants.
  always_comb begin
    lineTotal = isPal ? LINE_W'(PAL_LINES)   : LINE_W'(NTSC_LINES);
    f2Line    = isPal ? LINE_W'(PAL_F2_LINE) : LINE_W'(NTSC_F2_LINE);
    act1      = isPal ? LINE_W'(PAL_ACT1)    : LINE_W'(NTSC_ACT1);
    act2      = isPal ? LINE_W'(PAL_ACT2)    : LINE_W'(NTSC_ACT2);
    skipLoad  = isPal ? SKIP_W'(PAL_SKIP - 1) : SKIP_W'(NTSC_SKIP - 1);
  end

  // Edge events: field toggles only count while sync is held low.
  assign hFall  = hPrev & ~hsyncN;
  assign toOdd  = fPrev & ~fieldIn & ~hsyncN;
  assign toEven = ~fPrev & fieldIn & ~hsyncN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPrev      <= 1'b1;
      fPrev      <= 1'b1;
      lineNum    <= LINE_W'(1);
      oddField   <= 1'b1;
      frameStart <= 1'b0;
    end else begin
      hPrev      <= hsyncN;
      fPrev      <= fieldIn;
      frameStart <= toOdd;
      if (toOdd) begin
        lineNum  <= LINE_W'(1);
        oddField <= 1'b1;
      end else if (toEven) begin
        lineNum  <= f2Line;
        oddField <= 1'b0;
      end else if (hFall) begin
        lineNum <= (lineNum >= lineTotal) ? LINE_W'(1) : lineNum + LINE_W'(1);
      end
    end
  end

  // Blanking: internal line ranges plus the optional external input.
  assign intBlank = (lineNum < act1) || ((lineNum >= f2Line) && (lineNum < act2));
  assign extBlank = blankEn & ~blankN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) blankOut <= 1'b1;
    else       blankOut <= intBlank | extBlank;
  end

  // Start delay after blanking, then a four-phase sample sequencer.
  assign capEn = ~blankOut && (skipCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      skipCnt <= '0;
      phase   <= 2'd0;
    end else if (blankOut) begin
      skipCnt <= skipLoad;
      phase   <= 2'd0;
    end else if (skipCnt != '0) begin
      skipCnt <= skipCnt - SKIP_W'(1);
    end else begin
      phase <= phase + 2'd1;
    end
  end

  always_comb begin
    strobe.capCb = capEn && (phase == 2'd0);
    strobe.capY0 = capEn && (phase == 2'd1);
    strobe.capCr = capEn && (phase == 2'd2);
    strobe.capY1 = capEn && (phase == 2'd3);
  end
endmodule

// File: rtl/sd_sync_dp.sv
`timescale 1ns/1ps
module sd_sync_dp
  import sd_sync_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  pixStrobe_t          strobe,
  input  logic [DATA_W-1:0]   pixIn,
  input  logic                hsyncN,
  input  logic                blankN,
  input  logic                fieldIn,
  output logic [2*DATA_W-1:0] yOut,
  output logic [DATA_W-1:0]   cbOut,
  output logic [DATA_W-1:0]   crOut,
  output logic                pixValid,
  output logic                syncH,
  output logic                syncBlank,
  output logic                syncV
);
  localparam int          SYNC_N   = 3;
  localparam logic [SYNC_N-1:0] SYNC_RST = 3'b011;

  logic [DATA_W-1:0] cbHold, y0Hold, crHold;
  logic [SYNC_N-1:0] syncIn, syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cbHold   <= '0;
      y0Hold   <= '0;
      crHold   <= '0;
      cbOut    <= '0;
      crOut    <= '0;
      yOut     <= '0;
      pixValid <= 1'b0;
    end else begin
      if (strobe.capCb) cbHold <= pixIn;
      if (strobe.capY0) y0Hold <= pixIn;
      if (strobe.capCr) crHold <= pixIn;
      pixValid <= strobe.capY1;
      if (strobe.capY1) begin
        cbOut <= cbHold;
        crOut <= crHold;
        yOut  <= {y0Hold, pixIn};
      end
    end
  end

  // Timing pass-through: horizontal, blank, field.
  assign syncIn = {fieldIn, blankN, hsyncN};

  for (genvar g = 0; g < SYNC_N; g++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[g] <= SYNC_RST[g];
      else       syncQ[g] <= syncIn[g];
    end
  end

  assign syncH     = syncQ[0];
  assign syncBlank = syncQ[1];
  assign syncV     = syncQ[2];
endmodule

// File: rtl/sd_sync_slave.sv
`timescale 1ns/1ps
module sd_sync_slave
  import sd_sync_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LINE_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hsyncN,
  input  logic                fieldIn,
  input  logic                blankN,
  input  logic                blankEn,
  input  logic                isPal,
  input  logic [DATA_W-1:0]   pixIn,
  output logic [LINE_W-1:0]   lineNum,
  output logic                oddField,
  output logic                frameStart,
  output logic                blankOut,
  output logic [2*DATA_W-1:0] yOut,
  output logic [DATA_W-1:0]   cbOut,
  output logic [DATA_W-1:0]   crOut,
  output logic                pixValid,
  output logic                syncH,
  output logic                syncBlank,
  output logic                syncV
);
  pixStrobe_t strobe;

  sd_sync_ctrl #(.LINE_W(LINE_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .hsyncN     (hsyncN),
    .fieldIn    (fieldIn),
    .blankN     (blankN),
    .blankEn    (blankEn),
    .isPal      (isPal),
    .lineNum    (lineNum),
    .oddField   (oddField),
    .frameStart (frameStart),
    .blankOut   (blankOut),
    .strobe     (strobe)
  );

  sd_sync_dp #(.DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pixIn     (pixIn),
    .hsyncN    (hsyncN),
    .blankN    (blankN),
    .fieldIn   (fieldIn),
    .yOut      (yOut),
    .cbOut     (cbOut),
    .crOut     (crOut),
    .pixValid  (pixValid),
    .syncH     (syncH),
    .syncBlank (syncBlank),
    .syncV     (syncV)
  );
endmodule

// File: rtl/sd_sync_slave_chk.sv
`timescale 1ns/1ps
module sd_sync_slave_chk #(
  parameter int LINE_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              hsyncN,
  input logic              fieldIn,
  input logic [LINE_W-1:0] lineNum,
  input logic              oddField,
  input logic              frameStart,
  input logic              blankOut,
  input logic              pixValid,
  input logic              syncH,
  input logic              syncV
);
  AST_FRAME_LINE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (lineNum == LINE_W'(1)) && oddField);                 // R3
  AST_FRAME_SYNC_LOW: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> !$past(hsyncN));                                       // R5
  AST_LINE_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    hsyncN |=> $stable(lineNum));                                         // R2
  AST_LINE_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    lineNum != '0);                                                       // R2
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> !pixValid);                                              // R9
  AST_NO_VALID_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    blankOut |=> !pixValid);                                              // R9
  AST_SYNC_H_FWD: assert property (@(posedge clk) disable iff (!rstN)
    hsyncN |=> syncH);                                                    // R10
  AST_SYNC_V_FWD: assert property (@(posedge clk) disable iff (!rstN)
    !fieldIn |=> !syncV);                                                 // R10
endmodule

bind sd_sync_slave sd_sync_slave_chk #(.LINE_W(LINE_W)) chk_i (.*);

// File: tb/sd_sync_slave_tb_top.sv
`timescale 1ns/1ps
module sd_sync_slave_tb_top;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, hsyncN, fieldIn, blankN, blankEn, isPal;
  logic [DW-1:0] pixIn;
  logic [9:0] lineNum;
  logic oddField, frameStart, blankOut, pixValid, syncH, syncBlank, syncV;
  logic [2*DW-1:0] yOut;
  logic [DW-1:0] cbOut, crOut;

  int total = 0, bad = 0;
  bit done = 1'b0, strict = 1'b0;
  logic [4*DW-1:0] expQ[$];

  sd_sync_slave dut_i (
    .clk(clk), .rstN(rstN), .hsyncN(hsyncN), .fieldIn(fieldIn), .blankN(blankN),
    .blankEn(blankEn), .isPal(isPal), .pixIn(pixIn), .lineNum(lineNum),
    .oddField(oddField), .frameStart(frameStart), .blankOut(blankOut),
    .yOut(yOut), .cbOut(cbOut), .crOut(crOut), .pixValid(pixValid),
    .syncH(syncH), .syncBlank(syncBlank), .syncV(syncV)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic lines(int n);
    for (int i = 0; i < n; i++) begin
      hsyncN = 1'b0; tick();
      hsyncN = 1'b1; tick();
    end
  endtask

  // Driver: feeds a distinct sample per clock and queues the expected groups.
  task automatic pixRun(int skip, int groups);
    logic [DW-1:0] cb, y0, cr, v;
    int guard = 0;
    cb = '0; y0 = '0; cr = '0;
    while (blankOut && guard < 100) begin tick(); guard++; end
    chk("R8", "blank cleared before run", blankOut, 0);
    strict = 1'b1;
    for (int j = 1; j <= skip - 1 + 4 * groups; j++) begin
      v = DW'(j * 7 + 3);
      pixIn = v;
      if (j >= skip) begin
        case ((j - skip) % 4)
          0: cb = v;
          1: y0 = v;
          2: cr = v;
          default: expQ.push_back({cb, y0, v, cr});
        endcase
      end
      tick();
    end
    repeat (3) tick();
    strict = 1'b0;
    chk("R9", "all groups emitted", expQ.size(), 0);
    expQ.delete();
  endtask

  // Monitor: pops expected groups as pixValid appears.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rstN && pixValid) begin
        if (expQ.size() == 0) begin
          if (strict) chk("R8", "valid before expected", 1, 0);
        end else begin
          logic [4*DW-1:0] e;
          e = expQ.pop_front();
          chk("R9", "group cb,y0y1,cr", {cbOut, yOut, crOut}, e);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; hsyncN = 1'b1; fieldIn = 1'b1; blankN = 1'b1;
    blankEn = 1'b0; isPal = 1'b1; pixIn = '0;
    repeat (3) tick();
    chk("R1", "lineNum", lineNum, 1);
    chk("R1", "oddField", oddField, 1);
    chk("R1", "frameStart", frameStart, 0);
    chk("R1", "blankOut", blankOut, 1);
    chk("R1", "pixValid", pixValid, 0);
    chk("R1", "syncH", syncH, 1);
    chk("R1", "syncBlank", syncBlank, 1);
    chk("R1", "syncV", syncV, 0);
    rstN = 1'b1; tick();

    // PAL frame start
    hsyncN = 1'b0; tick();
    chk("R2", "line after hsync fall", lineNum, 2);
    fieldIn = 1'b0; tick();
    chk("R3", "frameStart pulse", frameStart, 1);
    chk("R3", "line reload", lineNum, 1);
    chk("R3", "odd field", oddField, 1);
    chk("R10", "syncH low", syncH, 0);
    chk("R10", "syncV low", syncV, 0);
    tick();
    chk("R3", "frameStart single", frameStart, 0);
    hsyncN = 1'b1; tick();
    lines(1);
    chk("R2", "line increment", lineNum, 2);

    // Field toggles with sync high
    fieldIn = 1'b1; tick(); tick();
    chk("R5", "line kept", lineNum, 2);
    chk("R5", "field kept", oddField, 1);
    chk("R5", "no frameStart", frameStart, 0);
    fieldIn = 1'b0; tick(); tick();
    chk("R5", "line kept after fall", lineNum, 2);
    chk("R5", "no frameStart after fall", frameStart, 0);
    chk("R6", "PAL line 2 blank", blankOut, 1);

    lines(20);
    chk("R6", "PAL line 22 blank", blankOut, 1);
    lines(1);
    chk("R2", "line 23", lineNum, 23);
    chk("R6", "PAL line 23 active", blankOut, 0);
    pixRun(12, 3);

    // External blank
    blankN = 1'b0; tick(); tick();
    chk("R7", "blankN ignored when disabled", blankOut, 0);
    chk("R10", "syncBlank follows", syncBlank, 0);
    blankEn = 1'b1; tick(); tick();
    chk("R7", "external blank", blankOut, 1);
    blankN = 1'b1; tick(); tick();
    chk("R7", "external blank released", blankOut, 0);
    blankEn = 1'b0;

    // PAL second field
    hsyncN = 1'b0; tick();
    fieldIn = 1'b1; tick();
    chk("R4", "PAL field2 line", lineNum, 313);
    chk("R4", "even field", oddField, 0);
    chk("R4", "no frameStart", frameStart, 0);
    chk("R10", "syncV high", syncV, 1);
    hsyncN = 1'b1; tick(); tick();
    chk("R6", "PAL line 313 blank", blankOut, 1);
    lines(22);
    chk("R6", "PAL line 335 blank", blankOut, 1);
    lines(1);
    chk("R6", "PAL line 336 active", blankOut, 0);
    lines(289);
    chk("R2", "PAL last line", lineNum, 625);
    hsyncN = 1'b0; tick();
    chk("R2", "PAL wrap", lineNum, 1);
    chk("R2", "wrap no frameStart", frameStart, 0);
    hsyncN = 1'b1; tick();

    // NTSC
    isPal = 1'b0;
    hsyncN = 1'b0; tick();
    fieldIn = 1'b0; tick();
    chk("R3", "NTSC frameStart", frameStart, 1);
    chk("R3", "NTSC line reload", lineNum, 1);
    hsyncN = 1'b1; tick(); tick();
    chk("R6", "NTSC line 1 blank", blankOut, 1);
    lines(19);
    chk("R6", "NTSC line 20 blank", blankOut, 1);
    lines(1);
    chk("R6", "NTSC line 21 active", blankOut, 0);
    pixRun(16, 2);
    hsyncN = 1'b0; tick();
    fieldIn = 1'b1; tick();
    chk("R4", "NTSC field2 line", lineNum, 263);
    chk("R4", "NTSC even field", oddField, 0);
    hsyncN = 1'b1; tick(); tick();
    chk("R6", "NTSC line 263 blank", blankOut, 1);
    lines(20);
    chk("R6", "NTSC line 283 blank", blankOut, 1);
    lines(1);
    chk("R6", "NTSC line 284 active", blankOut, 0);
    lines(241);
    chk("R2", "NTSC last line", lineNum, 525);
    hsyncN = 1'b0; tick();
    chk("R2", "NTSC wrap", lineNum, 1);
    hsyncN = 1'b1; tick();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule